// File: doc/BRIEF.md
# Reversed-Priority Quota Switch Allocator

This block is a two-stage separable switch allocator for one group of router ports shared by two security domains. Each input offers one request per virtual channel together with the output that channel wants. The first stage picks at most one virtual channel per input. The second stage picks at most one input per output. Both stages use one domain-aware arbiter. In that arbiter the low-security (LS) domain always takes precedence over the high-security (HS) domain. Because of this, nothing HS requests can shift when LS is served.

To stop LS from starving HS, every arbiter counts the grants it gives LS within a fixed interval of `INTERVAL` cycles. Once that count reaches `LS_QUOTA`, LS requests at that arbiter are masked until the interval ends. For example, 8 of 10 cycles sets a limit of 0.8 flit/cycle. Each arbiter holds a two-state quota machine. In `Q_OPEN`, LS is eligible. In `Q_SPENT`, LS is masked. The transition `OPEN->SPENT` fires when an LS grant brings the count to the quota. The transition `SPENT->OPEN` fires at the first cycle of the next interval. In that first cycle the count reads as zero whatever state it held. A shared free-running phase counter marks the interval starts. Within a domain, a round-robin pointer of that domain breaks ties.

Top module: `rpsl_switch_alloc`

## Requirements
- R1: Per input, `vc_gnt` is zero or one-hot, and it is set only on a requested VC. Bit `i*NUM_VC+v` stands for VC v of input i.
- R2: Per output, `out_gnt` grants at most one input, and no input is granted more than one output. Bit `o*NUM_IN+i` means output o is granted to input i. An input is granted only for the output its stage-1 winner targets. Target field of VC `i*NUM_VC+v` is `vc_dest[(i*NUM_VC+v)*OW +: OW]`.
- R3: At both stages an eligible LS request beats any HS request.
- R4: The lower half of each input's VCs carry LS traffic and the upper half carry HS traffic. With the default of four VCs, VCs 0–1 are LS and VCs 2–3 are HS.
- R5: An arbiter gives at most `LS_QUOTA` LS grants per interval. After the quota is reached, LS is masked there for the rest of the interval and HS is served.
- R6: An interval begins on the first cycle after reset and then every `INTERVAL` cycles. The LS count is zero at the start of every interval, whatever the traffic was.
- R7: `in_ls_exhausted[i]` and `out_ls_exhausted[o]` are high exactly while that arbiter is in `Q_SPENT`.
- R8: Within a domain, the search starts at that domain's round-robin pointer and wraps. The pointer moves to one past the winner only when that domain is granted at that arbiter.
- R9: LS stage-1 grants, LS output grants and LS status are cycle-for-cycle identical whether or not HS requests are present.
- R10: While `rst_n` is low, no grant and no status bit is asserted, even with requests present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vc_req | input | NUM_IN*NUM_VC | Request per VC of each input |
| vc_dest | input | NUM_IN*NUM_VC*OW | Target output per VC |
| vc_gnt | output | NUM_IN*NUM_VC | Stage-1 grant, one-hot per input |
| out_gnt | output | NUM_OUT*NUM_IN | Stage-2 grant, one-hot per output |
| in_ls_exhausted | output | NUM_IN | LS quota spent at input arbiter |
| out_ls_exhausted | output | NUM_OUT | LS quota spent at output arbiter |

## Verification
A vector table drives LS-only, HS-only and mixed patterns. Each row checks the pointer position that the earlier rows left behind. This shows whether the precedence rule holds and whether each domain's pointer moves only on its own grants. A saturating pattern sets one LS flow against one HS flow into the same output. It shows the exact cycle at which the quota masks LS and HS takes over, and the cycle at which the next interval restores LS. A long pseudo-random run drives a second instance with the HS bits stripped. Any difference in the LS-visible grants or status between the two instances shows HS-to-LS leakage.

// File: rtl/rpsl_pkg.sv
package rpsl_pkg;
    typedef enum logic {Q_OPEN, Q_SPENT} qstate_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rpsl_interval_timer.sv
module rpsl_interval_timer #(
    parameter int INTERVAL = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic interval_start
);
    localparam int TW = rpsl_pkg::idx_w(INTERVAL);

    logic [TW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == TW'(INTERVAL - 1))
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign interval_start = (phase_q == '0);

    assert_phase_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < TW'(INTERVAL));
endmodule

// File: rtl/rpsl_dom_arb.sv
module rpsl_dom_arb
    import rpsl_pkg::*;
#(
    parameter int N     = 4,
    parameter int QUOTA = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         interval_start,
    input  logic [N-1:0] req,
    input  logic [N-1:0] ls_flag,
    output logic [N-1:0] gnt,
    output logic         ls_exhausted
);
    localparam int PW = idx_w(N);
    localparam int CW = $clog2(QUOTA + 1);

    qstate_t        st_q, st_eff, st_nx;
    logic [CW-1:0]  cnt_q, cnt_eff, cnt_nx;
    logic [PW-1:0]  ls_ptr_q, hs_ptr_q, ls_ptr_nx, hs_ptr_nx;
    logic [N-1:0]   ls_req, hs_req;
    logic           ls_win, hs_win;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= Q_OPEN;
            cnt_q    <= '0;
            ls_ptr_q <= '0;
            hs_ptr_q <= '0;
        end else begin
            st_q     <= st_nx;
            cnt_q    <= cnt_nx;
            ls_ptr_q <= ls_ptr_nx;
            hs_ptr_q <= hs_ptr_nx;
        end
    end

    // grant and next-state logic
    always_comb begin
        st_eff       = interval_start ? Q_OPEN : st_q;
        cnt_eff      = interval_start ? '0 : cnt_q;
        ls_exhausted = rst_n && (st_eff == Q_SPENT);
        ls_req       = req & ls_flag & {N{~ls_exhausted}};
        hs_req       = req & ~ls_flag;
        gnt          = '0;
        ls_win       = 1'b0;
        hs_win       = 1'b0;
        ls_ptr_nx    = ls_ptr_q;
        hs_ptr_nx    = hs_ptr_q;
        if (rst_n) begin
            for (int k = 0; k < N; k++) begin
                int idx;
                idx = (int'(ls_ptr_q) + k) % N;
                if (!ls_win && ls_req[idx]) begin
                    ls_win    = 1'b1;
                    gnt[idx]  = 1'b1;
                    ls_ptr_nx = PW'((idx + 1) % N);
                end
            end
            if (!ls_win) begin
                for (int k = 0; k < N; k++) begin
                    int idx;
                    idx = (int'(hs_ptr_q) + k) % N;
                    if (!hs_win && hs_req[idx]) begin
                        hs_win    = 1'b1;
                        gnt[idx]  = 1'b1;
                        hs_ptr_nx = PW'((idx + 1) % N);
                    end
                end
            end
        end
        cnt_nx = cnt_eff + CW'(ls_win);
        st_nx  = st_eff;
        unique case (st_eff)
            Q_OPEN:  if (ls_win && cnt_nx == CW'(QUOTA)) st_nx = Q_SPENT;
            Q_SPENT: st_nx = Q_SPENT;
        endcase
    end

    assert_gnt_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_gnt_on_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    assert_ls_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(gnt & ~ls_flag)) |-> (!(|(req & ls_flag)) || ls_exhausted));
    assert_quota_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(QUOTA));
    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        interval_start |=> cnt_q <= CW'(1));
    assert_spent_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ls_exhausted |-> (gnt & ls_flag) == '0);
endmodule

// File: rtl/rpsl_switch_alloc.sv
module rpsl_switch_alloc
    import rpsl_pkg::*;
#(
    parameter int NUM_IN   = 2,
    parameter int NUM_OUT  = 2,
    parameter int NUM_VC   = 4,
    parameter int INTERVAL = 10,
    parameter int LS_QUOTA = 8,
    localparam int OW      = idx_w(NUM_OUT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_IN*NUM_VC-1:0]     vc_req,
    input  logic [NUM_IN*NUM_VC*OW-1:0]  vc_dest,
    output logic [NUM_IN*NUM_VC-1:0]     vc_gnt,
    output logic [NUM_OUT*NUM_IN-1:0]    out_gnt,
    output logic [NUM_IN-1:0]            in_ls_exhausted,
    output logic [NUM_OUT-1:0]           out_ls_exhausted
);
    localparam int LS_VCS = NUM_VC / 2;
    localparam logic [NUM_VC-1:0] LS_MASK = {NUM_VC{1'b1}} >> (NUM_VC - LS_VCS);

    logic                interval_start;
    logic [NUM_IN-1:0]   in_valid, in_ls;
    logic [OW-1:0]       in_dest [NUM_IN];
    logic [NUM_IN-1:0]   s2_req  [NUM_OUT];

    rpsl_interval_timer #(.INTERVAL(INTERVAL)) timer_i (
        .clk(clk), .rst_n(rst_n), .interval_start(interval_start)
    );

    // stage 1: one VC per input
    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        logic [NUM_VC-1:0] g1;

        rpsl_dom_arb #(.N(NUM_VC), .QUOTA(LS_QUOTA)) in_arb_i (
            .clk(clk), .rst_n(rst_n), .interval_start(interval_start),
            .req(vc_req[i*NUM_VC +: NUM_VC]), .ls_flag(LS_MASK),
            .gnt(g1), .ls_exhausted(in_ls_exhausted[i])
        );

        assign vc_gnt[i*NUM_VC +: NUM_VC] = g1;

        always_comb begin
            in_dest[i] = '0;
            for (int v = 0; v < NUM_VC; v++)
                if (g1[v]) in_dest[i] = vc_dest[(i*NUM_VC+v)*OW +: OW];
            in_valid[i] = |g1;
            in_ls[i]    = |(g1 & LS_MASK);
        end
    end

    always_comb begin
        for (int o = 0; o < NUM_OUT; o++)
            for (int i = 0; i < NUM_IN; i++)
                s2_req[o][i] = in_valid[i] && (in_dest[i] == OW'(o));
    end

    // stage 2: one input per output
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        rpsl_dom_arb #(.N(NUM_IN), .QUOTA(LS_QUOTA)) out_arb_i (
            .clk(clk), .rst_n(rst_n), .interval_start(interval_start),
            .req(s2_req[o]), .ls_flag(in_ls),
            .gnt(out_gnt[o*NUM_IN +: NUM_IN]), .ls_exhausted(out_ls_exhausted[o])
        );
    end

    for (genvar i = 0; i < NUM_IN; i++) begin : g_col
        logic [NUM_OUT-1:0] col;
        always_comb
            for (int o = 0; o < NUM_OUT; o++) col[o] = out_gnt[o*NUM_IN+i];

        assert_one_out_per_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(col) <= 1);
        assert_out_needs_s1_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (|col) |-> (|vc_gnt[i*NUM_VC +: NUM_VC]));
    end
endmodule

// File: tb/rpsl_switch_alloc_tb_top.sv
`timescale 1ns/1ps
module rpsl_switch_alloc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] vc_req = '0, vc_dest = '0;
    logic [7:0] vc_gnt, ref_vc_gnt;
    logic [3:0] out_gnt, ref_out_gnt;
    logic [1:0] in_exh, out_exh, ref_in_exh, ref_out_exh;
    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    rpsl_switch_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .vc_req(vc_req), .vc_dest(vc_dest),
        .vc_gnt(vc_gnt), .out_gnt(out_gnt),
        .in_ls_exhausted(in_exh), .out_ls_exhausted(out_exh)
    );

    // same flows with HS requests removed (VCs 2,3 of each input are HS)
    rpsl_switch_alloc ref_i (
        .clk(clk), .rst_n(rst_n), .vc_req(vc_req & 8'h33), .vc_dest(vc_dest),
        .vc_gnt(ref_vc_gnt), .out_gnt(ref_out_gnt),
        .in_ls_exhausted(ref_in_exh), .out_ls_exhausted(ref_out_exh)
    );

    // {vc_req, vc_dest, expected vc_gnt, expected out_gnt}
    localparam logic [31:0] TBL [7] = '{
        {8'h41, 8'h00, 8'h41, 8'h01},  // R3 R4 LS beats HS at out0
        {8'h88, 8'h88, 8'h88, 8'h04},  // R8 HS only, out1 picks in0
        {8'h88, 8'h88, 8'h88, 8'h08},  // R8 HS pointer moved to in1
        {8'h23, 8'h23, 8'h22, 8'h04},  // R8 LS pointers
        {8'h23, 8'h23, 8'h21, 8'h08},  // R8 LS pointer wraps
        {8'h94, 8'h80, 8'h14, 8'h02},  // R3 mixed domains at both stages
        {8'h00, 8'h00, 8'h00, 8'h00}   // R1 no request, no grant
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        vc_req = '0;
        vc_dest = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: reset holds everything low despite requests
        rst_n = 1'b0;
        vc_req = 8'hFF;
        vc_dest = 8'h00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 vc_gnt in reset", 32'(vc_gnt), 0);
        check("R10 out_gnt in reset", 32'(out_gnt), 0);
        check("R10 status in reset", 32'({in_exh, out_exh}), 0);

        // vector table
        do_reset();
        for (int r = 0; r < 7; r++) begin
            vc_req  = TBL[r][31:24];
            vc_dest = TBL[r][23:16];
            @(negedge clk);
            check($sformatf("R1/R3/R8 row%0d vc_gnt", r), 32'(vc_gnt), 32'(TBL[r][15:8]));
            check($sformatf("R2/R3/R8 row%0d out_gnt", r), 32'(out_gnt), 32'(TBL[r][3:0]));
            next_cycle();
        end

        // saturation: LS in0 VC0 and HS in1 VC2 both to out0
        do_reset();
        for (int k = 0; k < 20; k++) begin
            int p;
            p = k % 10;
            vc_req  = 8'h41;
            vc_dest = 8'h00;
            @(negedge clk);
            if (p < 8) begin
                check($sformatf("R5/R6 cyc%0d vc_gnt", k), 32'(vc_gnt), 32'h41);
                check($sformatf("R5/R6 cyc%0d out_gnt", k), 32'(out_gnt), 32'h1);
                check($sformatf("R7 cyc%0d status", k), 32'({in_exh, out_exh}), 0);
            end else begin
                check($sformatf("R5 cyc%0d vc_gnt masked", k), 32'(vc_gnt), 32'h40);
                check($sformatf("R5 cyc%0d out_gnt HS", k), 32'(out_gnt), 32'h2);
                check($sformatf("R7 cyc%0d status", k), 32'({in_exh, out_exh}), 32'b0101);
            end
            next_cycle();
        end

        // R9: random traffic, compare against the HS-stripped copy
        do_reset();
        begin
            logic [15:0] lfsr;
            int ls_cnt [2];
            lfsr = 16'hACE1;
            ls_cnt = '{0, 0};
            for (int k = 0; k < 400; k++) begin
                logic [1:0] ls_sel;
                logic [3:0] dut_ls_out;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                vc_req  = (k % 50 < 25) ? (lfsr[7:0] | 8'hCC) : lfsr[7:0];
                vc_dest = lfsr[15:8];
                @(negedge clk);
                for (int i = 0; i < 2; i++) ls_sel[i] = |(vc_gnt[i*4 +: 4] & 4'h3);
                for (int o = 0; o < 2; o++)
                    for (int i = 0; i < 2; i++)
                        dut_ls_out[o*2+i] = out_gnt[o*2+i] & ls_sel[i];
                check($sformatf("R9 cyc%0d LS vc_gnt", k), 32'(vc_gnt & 8'h33), 32'(ref_vc_gnt));
                check($sformatf("R9 cyc%0d LS out_gnt", k), 32'(dut_ls_out), 32'(ref_out_gnt));
                check($sformatf("R9 cyc%0d LS status", k),
                      32'({in_exh, out_exh}), 32'({ref_in_exh, ref_out_exh}));
                for (int o = 0; o < 2; o++) ls_cnt[o] += $countones(dut_ls_out[o*2 +: 2]);
                if (k % 10 == 9) begin
                    for (int o = 0; o < 2; o++) begin
                        check($sformatf("R5 interval%0d out%0d LS quota", k / 10, o),
                              32'(ls_cnt[o] <= 8), 1);
                        ls_cnt[o] = 0;
                    end
                end
                next_cycle();
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule